// File: doc/BRIEF.md
# Bus Idle and Transmit Permit Timer

This block watches the receive line of a shared serial bus and measures how long the line has stayed quiet. It counts in bit-time units, one unit for each strobe on `bit_tick`. From that count it decides two things: when the bus counts as idle, and when this node may begin to transmit. Each node on the bus gets its own permit delay, counted from the last bus activity. A shorter delay gives a node higher priority. A node can raise its delay at any time so that it yields to other nodes when its traffic is unimportant.

Three access disciplines are selected by mode bits. In shared (arbitration) and plain half-duplex operation, a node that is waiting to send gets permission once the quiet time reaches its permit delay. Break-sync operation is stricter: a node may start only at the exact unit where its permit delay is reached. A node that missed that point waits until the quiet time goes past a maximum idle length. It then asks for a break character to wake the bus. Full-duplex operation does not share the line, so a pending frame is permitted at once. Byte serialisation and break transmission belong to a neighbouring block, which consumes `tx_permit` and `send_break`.

All pins are plain control and status signals. The block has no data stream and no valid/ready handshake. `tx_permit` and `send_break` are single-cycle pulses. The transmitter holds `tx_pending` high until it has finished sending, and it lowers `tx_pending` to re-arm the block.

Top module: `bus_gap_timer`

## Requirements
- R1: After reset `bus_idle`, `tx_permit` and `send_break` are all 0, and the quiet count is zero.
- R2: The quiet count goes up by one on each clock with `bit_tick` high while the registered line is high. `bus_idle` is 1 once the count is at least `idle_wait_len`. With `idle_wait_len` = 10, that is after the 10th tick that follows the line going high.
- R3: Clocks with `bit_tick` low do not advance the count.
- R4: A low line, whether a falling edge or a held break character, clears `bus_idle` and returns the count to zero. A full `idle_wait_len` of ticks is then needed again after the line goes high.
- R5: In shared mode (`arb_en`=1), and in plain half-duplex mode (all mode bits 0), a pending node gets `tx_permit` when the count first reaches `tx_permit_len`. The pulse lasts one cycle, and no further pulse comes while `tx_pending` stays high.
- R6: In shared mode, a request that arrives after the permit point gets `tx_permit` in the same cycle, provided the line is high.
- R7: `tx_permit_len` is compared live. Raising it before the count reaches it postpones the permit to the new value.
- R8: In break-sync mode (`bsync_en`=1, `fdx_en`=0), `tx_permit` fires only while the count equals `tx_permit_len`.
- R9: In break-sync mode, a pending node that has had no permit pulses `send_break` for one cycle once the count exceeds `max_idle_len`. `tx_permit` and `send_break` are never both high.
- R10: In full-duplex mode (`fdx_en`=1, which takes priority over the other bits), `tx_permit` pulses in the cycle `tx_pending` rises, whatever the line level. Lowering `tx_pending` re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Bus receive line, high when quiet |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| arb_en | input | 1 | Shared (arbitration) access mode |
| bsync_en | input | 1 | Break-sync access mode |
| fdx_en | input | 1 | Full-duplex mode, highest precedence |
| idle_wait_len | input | 8 | Quiet units before the bus counts as idle |
| tx_permit_len | input | 10 | Quiet units before this node may send |
| max_idle_len | input | 10 | Break-sync limit before a break is requested |
| tx_pending | input | 1 | A frame waits to be sent; held until done |
| bus_idle | output | 1 | Bus is idle |
| tx_permit | output | 1 | One-cycle pulse: start the frame now |
| send_break | output | 1 | One-cycle pulse: send a break character |

## Verification
The idle-rise check takes `idle_wait_len` to be non-zero and to hold steady while the count approaches it. The bench changes that value only while the line is held low. The one-pulse and exclusivity checks assume that `tx_pending` drops only between frames. The bench raises and lowers it on cycle boundaries and leaves it high across each scenario. Mode bits are changed only while the line is low or no request is pending.

// File: rtl/bus_gap_pkg.sv
package bus_gap_pkg;
  typedef enum logic [1:0] {
    ACC_PLAIN = 2'd0,
    ACC_ARB   = 2'd1,
    ACC_BSYNC = 2'd2,
    ACC_FDX   = 2'd3
  } access_mode_e;

  function automatic access_mode_e decode_mode(input logic arb, input logic bsync,
                                               input logic fdx);
    if (fdx)        return ACC_FDX;
    else if (bsync) return ACC_BSYNC;
    else if (arb)   return ACC_ARB;
    else            return ACC_PLAIN;
  endfunction
endpackage

// File: rtl/bus_gap_watch.sv
module bus_gap_watch #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic             bit_tick,
  output logic             line_hi,
  output logic [CNT_W-1:0] quiet_cnt
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  // register the line once; a low level (edge or break) is activity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_hi   <= 1'b1;
      quiet_cnt <= '0;
    end else begin
      line_hi <= rx_line;
      if (!line_hi)
        quiet_cnt <= '0;
      else if (bit_tick && quiet_cnt != SAT)
        quiet_cnt <= quiet_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bus_gap_grant.sv
module bus_gap_grant
  import bus_gap_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  access_mode_e     mode,
  input  logic             line_hi,
  input  logic [CNT_W-1:0] quiet_cnt,
  input  logic [LEN_W-1:0] permit_len,
  input  logic [LEN_W-1:0] max_idle,
  input  logic             pending,
  output logic             permit,
  output logic             brk_req
);
  localparam int PAD = CNT_W - LEN_W;

  logic             granted;
  logic [CNT_W-1:0] permit_ext;
  logic [CNT_W-1:0] max_ext;
  logic             armed;

  assign permit_ext = {{PAD{1'b0}}, permit_len};
  assign max_ext    = {{PAD{1'b0}}, max_idle};
  assign armed      = pending && !granted;

  always_comb begin
    permit  = 1'b0;
    brk_req = 1'b0;
    unique case (mode)
      ACC_FDX:   permit = armed;
      ACC_BSYNC: begin
        permit  = armed && line_hi && (quiet_cnt == permit_ext);
        brk_req = armed && line_hi && (quiet_cnt > max_ext) && (quiet_cnt != permit_ext);
      end
      default:   permit = armed && line_hi && (quiet_cnt >= permit_ext);
    endcase
  end

  // one grant per request; activity on a shared bus also re-arms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      granted <= 1'b0;
    else if (!pending)
      granted <= 1'b0;
    else if (!line_hi && mode != ACC_FDX)
      granted <= 1'b0;
    else if (permit || brk_req)
      granted <= 1'b1;
  end
endmodule

// File: rtl/bus_gap_timer.sv
module bus_gap_timer
  import bus_gap_pkg::*;
#(
  parameter int WAIT_W = 8,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              bit_tick,
  input  logic              arb_en,
  input  logic              bsync_en,
  input  logic              fdx_en,
  input  logic [WAIT_W-1:0] idle_wait_len,
  input  logic [LEN_W-1:0]  tx_permit_len,
  input  logic [LEN_W-1:0]  max_idle_len,
  input  logic              tx_pending,
  output logic              bus_idle,
  output logic              tx_permit,
  output logic              send_break
);
  localparam int CNT_W = ((LEN_W > WAIT_W) ? LEN_W : WAIT_W) + 1;

  logic             line_hi;
  logic [CNT_W-1:0] quiet_cnt;
  access_mode_e     mode;

  assign mode = decode_mode(arb_en, bsync_en, fdx_en);

  bus_gap_watch #(.CNT_W(CNT_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
    .line_hi(line_hi), .quiet_cnt(quiet_cnt)
  );

  assign bus_idle = line_hi && (quiet_cnt >= {{(CNT_W-WAIT_W){1'b0}}, idle_wait_len});

  bus_gap_grant #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_grant (
    .clk(clk), .rst_n(rst_n), .mode(mode), .line_hi(line_hi),
    .quiet_cnt(quiet_cnt), .permit_len(tx_permit_len), .max_idle(max_idle_len),
    .pending(tx_pending), .permit(tx_permit), .brk_req(send_break)
  );
endmodule

// File: rtl/bus_gap_timer_chk.sv
module bus_gap_timer_chk #(
  parameter int WAIT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_line,
  input logic              bit_tick,
  input logic              bsync_en,
  input logic              fdx_en,
  input logic [WAIT_W-1:0] idle_wait_len,
  input logic              tx_pending,
  input logic              bus_idle,
  input logic              tx_permit,
  input logic              send_break
);
  // R4
  low_line_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rx_line)) |-> !bus_idle);

  // R2
  idle_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_idle) && idle_wait_len != '0 && $stable(idle_wait_len)) |-> $past(bit_tick));

  // R5
  single_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |=> !tx_permit);

  // R9
  permit_break_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_permit && send_break));

  // R9
  break_only_bsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_break |-> (bsync_en && !fdx_en && tx_pending));

  // R10
  permit_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |-> tx_pending);
endmodule

bind bus_gap_timer bus_gap_timer_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
  .bsync_en(bsync_en), .fdx_en(fdx_en), .idle_wait_len(idle_wait_len),
  .tx_pending(tx_pending), .bus_idle(bus_idle), .tx_permit(tx_permit),
  .send_break(send_break)
);

// File: tb/bus_gap_timer_test.sv
`timescale 1ns/1ps
module bus_gap_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       bit_tick = 1'b0;
  logic       arb_en = 1'b1, bsync_en = 1'b0, fdx_en = 1'b0;
  logic [7:0] idle_wait_len = 8'd10;
  logic [9:0] tx_permit_len = 10'd20;
  logic [9:0] max_idle_len = 10'd200;
  logic       tx_pending = 1'b0;
  logic       bus_idle, tx_permit, send_break;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_gap_timer uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
    .arb_en(arb_en), .bsync_en(bsync_en), .fdx_en(fdx_en),
    .idle_wait_len(idle_wait_len), .tx_permit_len(tx_permit_len),
    .max_idle_len(max_idle_len), .tx_pending(tx_pending),
    .bus_idle(bus_idle), .tx_permit(tx_permit), .send_break(send_break)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one clock with the given tick value; returns at the next falling edge
  task automatic cyc(input logic t);
    bit_tick = t;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  // hold the line low, then release it; afterwards the quiet count is zero
  task automatic restart_bus();
    rx_line = 1'b0;
    cyc(1'b1); cyc(1'b1);
    rx_line = 1'b1;
    cyc(1'b1);
  endtask

  task automatic t_reset();
    check("R1", "idle after reset", bus_idle, 1'b0);
    check("R1", "permit after reset", tx_permit, 1'b0);
    check("R1", "break after reset", send_break, 1'b0);
  endtask

  task automatic t_idle();
    restart_bus();
    ticks(9);
    check("R2", "idle at 9 ticks", bus_idle, 1'b0);
    cyc(1'b0); cyc(1'b0); cyc(1'b0);
    check("R3", "no advance without tick", bus_idle, 1'b0);
    ticks(1);
    check("R2", "idle at 10 ticks", bus_idle, 1'b1);
  endtask

  task automatic t_activity();
    rx_line = 1'b0;
    cyc(1'b1);
    check("R4", "falling edge clears idle", bus_idle, 1'b0);
    ticks(30);
    check("R4", "held break keeps idle low", bus_idle, 1'b0);
    rx_line = 1'b1;
    cyc(1'b1);
    ticks(9);
    check("R4", "full wait needed again (9)", bus_idle, 1'b0);
    ticks(1);
    check("R4", "full wait needed again (10)", bus_idle, 1'b1);
  endtask

  task automatic t_arb(input logic arb);
    arb_en = arb;
    tx_pending = 1'b1;
    restart_bus();
    ticks(19);
    check(arb ? "R5" : "r5_plain", "no permit before point", tx_permit, 1'b0);
    ticks(1);
    check(arb ? "R5" : "r5_plain", "permit at point", tx_permit, 1'b1);
    ticks(1);
    check(arb ? "R5" : "r5_plain", "single pulse", tx_permit, 1'b0);
    tx_pending = 1'b0;
    arb_en = 1'b1;
  endtask

  task automatic t_late();
    restart_bus();
    ticks(30);
    tx_pending = 1'b1;
    #1;
    check("R6", "late request permitted at once", tx_permit, 1'b1);
    cyc(1'b1);
    check("R6", "late pulse single", tx_permit, 1'b0);
    tx_pending = 1'b0;
  endtask

  task automatic t_stretch();
    tx_pending = 1'b1;
    restart_bus();
    ticks(15);
    tx_permit_len = 10'd40;
    ticks(5);
    check("R7", "no permit at old point", tx_permit, 1'b0);
    ticks(19);
    check("R7", "no permit at 39", tx_permit, 1'b0);
    ticks(1);
    check("R7", "permit at new point", tx_permit, 1'b1);
    tx_pending = 1'b0;
    tx_permit_len = 10'd20;
  endtask

  task automatic t_bsync();
    arb_en = 1'b0; bsync_en = 1'b1; max_idle_len = 10'd50;
    tx_pending = 1'b1;
    restart_bus();
    ticks(20);
    check("R8", "permit exactly at point", tx_permit, 1'b1);
    tx_pending = 1'b0;
    restart_bus();
    ticks(25);
    tx_pending = 1'b1;
    #1;
    check("R8", "no permit after point", tx_permit, 1'b0);
    ticks(25);
    check("R9", "no break at max idle", send_break, 1'b0);
    ticks(1);
    check("R9", "break past max idle", send_break, 1'b1);
    check("R9", "no permit with break", tx_permit, 1'b0);
    ticks(1);
    check("R9", "break single pulse", send_break, 1'b0);
    tx_pending = 1'b0;
    bsync_en = 1'b0; arb_en = 1'b1; max_idle_len = 10'd200;
  endtask

  task automatic t_fdx();
    fdx_en = 1'b1; bsync_en = 1'b1;
    rx_line = 1'b0;
    cyc(1'b1); cyc(1'b1);
    tx_pending = 1'b1;
    #1;
    check("R10", "immediate permit with line low", tx_permit, 1'b1);
    cyc(1'b0);
    check("R10", "single pulse", tx_permit, 1'b0);
    tx_pending = 1'b0;
    cyc(1'b0);
    tx_pending = 1'b1;
    #1;
    check("R10", "re-armed after drop", tx_permit, 1'b1);
    cyc(1'b0);
    tx_pending = 1'b0;
    fdx_en = 1'b0; bsync_en = 1'b0;
    rx_line = 1'b1;
    cyc(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_idle();
    t_activity();
    t_arb(1'b1);
    t_arb(1'b0);
    t_late();
    t_stretch();
    t_bsync();
    t_fdx();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule